// File: doc/BRIEF.md
# Descriptor Ring Consumer

The block walks a circular ring of 64-byte descriptors held in host memory and hands each one that the host has given to the device to a downstream engine. A consumer index selects the slot; the block reads that slot one 64-bit word at a time through a simple read request/response port. The first word carries the ownership byte and the message type. When the ownership byte is anything but the device value, the block stops reading the slot and waits. It retries after a fixed number of idle cycles, or at once when a doorbell strobe arrives. When the slot is device-owned, the block reads the rest of the slot: a 64-bit cookie and three length/pointer pairs. It trims the pair list at the first zero length and presents the result on a valid/ready output stage.

The same block serves either a command ring or a reply ring, selected by a static input. In reply mode the downstream side claims a buffer with a single-cycle request strobe. A claim that finds no descriptor waiting is a dropped reply, and a reply descriptor with no usable buffer is a fault. A read error response is also a fault. Any of these errors stops the block until reset.

Back-pressure rules for the read request side: `rd_req_valid` stays high with an unchanged address until `rd_req_ready` is seen, and a new request is made only after the response to the previous one. The response comes back as a one-cycle `rd_rsp_valid` pulse. On the output side, `out_valid` and all output fields hold until the descriptor is taken. In command mode it is taken by `out_ready`. In reply mode it is taken by `reply_need`, and `out_ready` is ignored. While `out_valid` is high, exactly one reply buffer is available.

Top module: `desc_ring_consumer`

## Requirements
- R1: After reset the block makes no read request, `out_valid` is low, `cons_idx` is 0 and both error outputs are low.
- R2: The slot at index i is read as eight little-endian 64-bit words at `ring_base + i*64 + k*8`, with k counting up from 0. In word 0, bits [7:0] are the ownership byte and bits [15:8] are the type. Word 1 is the cookie. For pair j (0..2), word 2+2j bits [31:0] give the length (bits [63:32] are ignored) and word 3+2j gives the pointer.
- R3: Only the ownership byte 0xAA is accepted. Any other value (host value 0x55 or otherwise) produces no output, leaves `cons_idx` unchanged, and causes exactly one read (word 0) for that poll.
- R4: After a poll that finds the slot not device-owned, the block polls the slot again on its own after `POLL_GAP` idle cycles, with no doorbell. A `db_strobe` while idle starts a poll at once.
- R5: `out_sg_cnt` equals the number of leading nonzero lengths. Every pair at or after the first zero length is presented with length 0 and pointer 0.
- R6: While the output is not taken, `out_valid` and every output field stay unchanged. When it is taken, `cons_idx` increases by one and the next slot is polled immediately.
- R7: The index after 2^`ring_shift` - 1 is 0, and `cons_idx` never reaches 2^`ring_shift`.
- R8: A read response with `rd_rsp_err` high sets `err_fetch_fault`, and the descriptor is not presented.
- R9: In reply mode, a device-owned descriptor whose three lengths are all zero sets `err_fetch_fault` and is not presented.
- R10: In reply mode, a `reply_need` pulse in a cycle with `out_valid` low sets `err_no_buf`. A pulse in the first cycle that `out_valid` is high takes the descriptor and sets no error.
- R11: Once either error output is high, it stays high, no further read request is made, `out_valid` stays low and doorbells have no effect, until reset.
- R12: A request that is not accepted is held with the same address, and no request is made while a response is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Allows polling; ring setup must be static while high |
| reply_mode | input | 1 | 1: reply ring rules, 0: command ring rules (static) |
| ring_base | input | AW | Byte address of slot 0 |
| ring_shift | input | SHW | Ring holds 2^ring_shift slots |
| db_strobe | input | 1 | Doorbell pulse for this ring |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | AW | 8-byte aligned read address |
| rd_rsp_valid | input | 1 | Read data valid (one cycle) |
| rd_rsp_data | input | 64 | Read data, little-endian |
| rd_rsp_err | input | 1 | Read faulted |
| out_valid | output | 1 | Decoded descriptor available |
| out_ready | input | 1 | Command mode: take the descriptor |
| reply_need | input | 1 | Reply mode: a reply wants a buffer |
| out_type | output | 8 | Message type |
| out_cookie | output | 64 | Host cookie |
| out_len | output | 3*32 | Trimmed lengths, pair j at [32j+31:32j] |
| out_ptr | output | 3*AW | Trimmed pointers, pair j at [AW*j+AW-1:AW*j] |
| out_sg_cnt | output | 2 | Number of usable pairs |
| cons_idx | output | MAX_SHIFT | Current consumer index |
| err_fetch_fault | output | 1 | Read fault or empty reply descriptor |
| err_no_buf | output | 1 | Reply dropped for lack of a descriptor |

## Verification
The interesting coincidence is a reply claim and the presentation of a reply descriptor landing in the same cycle. The bench watches for `out_valid` and raises `reply_need` in the very first cycle that it is high. It then judges that the descriptor was taken: `cons_idx` moved to 1 and `err_no_buf` stayed low. A separate run raises the claim while nothing is presented and expects the drop error and a silent read port. A doorbell that meets a timer-driven poll is kept out of the measurement windows, so the count of word reads per miss is exact.

// File: rtl/dring_pkg.sv
package dring_pkg;
  localparam int WORD_W     = 64;
  localparam int DESC_WORDS = 8;
  localparam int DESC_SHIFT = $clog2(DESC_WORDS * WORD_W / 8);
  localparam int SG_PAIRS   = (DESC_WORDS - 2) / 2;
  localparam int LEN_W      = 32;
  localparam int SGC_W      = $clog2(SG_PAIRS + 1);

  localparam logic [7:0] OWN_DEVICE = 8'hAA;
  localparam logic [7:0] OWN_HOST   = 8'h55;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_CHK,
    ST_OUT,
    ST_HALT
  } fetch_st_e;
endpackage

// File: rtl/dring_index.sv
module dring_index #(
  parameter int MAX_SHIFT = 12,
  parameter int SHW       = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 advance,
  input  logic [SHW-1:0]       shift,
  output logic [MAX_SHIFT-1:0] idx
);
  logic [MAX_SHIFT:0]   span;
  logic [MAX_SHIFT-1:0] mask;
  logic [MAX_SHIFT-1:0] nxt;

  always_comb begin
    span = (MAX_SHIFT + 1)'(1) << shift;
    mask = MAX_SHIFT'(span - 1'b1);
    nxt  = (idx + MAX_SHIFT'(1)) & mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx <= '0;
    else if (advance) idx <= nxt;
  end
endmodule

// File: rtl/dring_poll_timer.sv
module dring_poll_timer #(
  parameter int GAP = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic idle,
  output logic fire
);
  localparam int CW = $clog2(GAP + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (!idle) cnt <= CW'(GAP);
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign fire = idle && (cnt == '0);
endmodule

// File: rtl/dring_sg_trim.sv
module dring_sg_trim
  import dring_pkg::*;
#(
  parameter int AW = 64
) (
  input  logic [SG_PAIRS*LEN_W-1:0] raw_len,
  input  logic [SG_PAIRS*AW-1:0]    raw_ptr,
  output logic [SG_PAIRS*LEN_W-1:0] len_o,
  output logic [SG_PAIRS*AW-1:0]    ptr_o,
  output logic [SGC_W-1:0]          cnt_o
);
  logic alive;

  always_comb begin
    alive = 1'b1;
    cnt_o = '0;
    len_o = '0;
    ptr_o = '0;
    for (int j = 0; j < SG_PAIRS; j++) begin
      if (alive && raw_len[j*LEN_W +: LEN_W] != '0) begin
        len_o[j*LEN_W +: LEN_W] = raw_len[j*LEN_W +: LEN_W];
        ptr_o[j*AW +: AW]       = raw_ptr[j*AW +: AW];
        cnt_o                   = cnt_o + 1'b1;
      end else begin
        alive = 1'b0;
      end
    end
  end
endmodule

// File: rtl/desc_ring_consumer.sv
module desc_ring_consumer
  import dring_pkg::*;
#(
  parameter int AW        = 64,
  parameter int MAX_SHIFT = 12,
  parameter int POLL_GAP  = 64,
  localparam int SHW      = $clog2(MAX_SHIFT + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      en,
  input  logic                      reply_mode,
  input  logic [AW-1:0]             ring_base,
  input  logic [SHW-1:0]            ring_shift,
  input  logic                      db_strobe,
  output logic                      rd_req_valid,
  input  logic                      rd_req_ready,
  output logic [AW-1:0]             rd_req_addr,
  input  logic                      rd_rsp_valid,
  input  logic [WORD_W-1:0]         rd_rsp_data,
  input  logic                      rd_rsp_err,
  output logic                      out_valid,
  input  logic                      out_ready,
  input  logic                      reply_need,
  output logic [7:0]                out_type,
  output logic [63:0]               out_cookie,
  output logic [SG_PAIRS*LEN_W-1:0] out_len,
  output logic [SG_PAIRS*AW-1:0]    out_ptr,
  output logic [SGC_W-1:0]          out_sg_cnt,
  output logic [MAX_SHIFT-1:0]      cons_idx,
  output logic                      err_fetch_fault,
  output logic                      err_no_buf
);
  localparam int WCW = $clog2(DESC_WORDS);

  fetch_st_e st;
  logic [WCW-1:0] wcnt;
  logic db_pend, poll_fire, go, take, drop_hit, capture;
  logic [7:0]  type_q;
  logic [63:0] cookie_q;
  logic [SG_PAIRS*LEN_W-1:0] raw_len;
  logic [SG_PAIRS*AW-1:0]    raw_ptr;

  // index and poll timing
  dring_index #(.MAX_SHIFT(MAX_SHIFT), .SHW(SHW)) u_idx (
    .clk(clk), .rst_n(rst_n), .advance(take), .shift(ring_shift), .idx(cons_idx)
  );

  dring_poll_timer #(.GAP(POLL_GAP)) u_tmr (
    .clk(clk), .rst_n(rst_n), .idle(st == ST_IDLE), .fire(poll_fire)
  );

  assign go       = (st == ST_IDLE) && en && (db_pend || db_strobe || poll_fire);
  assign take     = (st == ST_OUT) && (reply_mode ? reply_need : out_ready);
  assign drop_hit = reply_mode && reply_need && (st != ST_OUT) && (st != ST_HALT);
  assign capture  = (st == ST_WAIT) && rd_rsp_valid && !rd_rsp_err;

  // request side
  assign rd_req_valid = (st == ST_REQ);
  assign rd_req_addr  = ring_base + (AW'(cons_idx) << DESC_SHIFT) + (AW'(wcnt) << 3);
  assign out_valid    = (st == ST_OUT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st              <= ST_IDLE;
      wcnt            <= '0;
      db_pend         <= 1'b0;
      err_fetch_fault <= 1'b0;
      err_no_buf      <= 1'b0;
    end else begin
      db_pend <= (db_strobe && st != ST_IDLE) || (db_pend && !go);
      if (drop_hit) begin
        err_no_buf <= 1'b1;
        st         <= ST_HALT;
      end else begin
        case (st)
          ST_IDLE: if (go) begin
            st   <= ST_REQ;
            wcnt <= '0;
          end
          ST_REQ: if (rd_req_ready) st <= ST_WAIT;
          ST_WAIT: if (rd_rsp_valid) begin
            if (rd_rsp_err) begin
              err_fetch_fault <= 1'b1;
              st              <= ST_HALT;
            end else if (wcnt == '0 && rd_rsp_data[7:0] != OWN_DEVICE) begin
              st <= ST_IDLE;
            end else if (wcnt == WCW'(DESC_WORDS - 1)) begin
              st <= ST_CHK;
            end else begin
              wcnt <= wcnt + 1'b1;
              st   <= ST_REQ;
            end
          end
          ST_CHK: if (reply_mode && out_sg_cnt == '0) begin
            err_fetch_fault <= 1'b1;
            st              <= ST_HALT;
          end else begin
            st <= ST_OUT;
          end
          ST_OUT: if (take) begin
            st   <= ST_REQ;
            wcnt <= '0;
          end
          ST_HALT: st <= ST_HALT;
          default: st <= ST_HALT;
        endcase
      end
    end
  end

  // field capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      type_q   <= '0;
      cookie_q <= '0;
    end else if (capture) begin
      if (wcnt == WCW'(0)) type_q <= rd_rsp_data[15:8];
      if (wcnt == WCW'(1)) cookie_q <= rd_rsp_data;
    end
  end

  for (genvar j = 0; j < SG_PAIRS; j++) begin : g_pair
    localparam int LEN_WORD = 2 + 2 * j;
    logic [LEN_W-1:0] len_q;
    logic [AW-1:0]    ptr_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        len_q <= '0;
        ptr_q <= '0;
      end else if (capture) begin
        if (wcnt == WCW'(LEN_WORD))     len_q <= rd_rsp_data[LEN_W-1:0];
        if (wcnt == WCW'(LEN_WORD + 1)) ptr_q <= AW'(rd_rsp_data);
      end
    end
    assign raw_len[j*LEN_W +: LEN_W] = len_q;
    assign raw_ptr[j*AW +: AW]       = ptr_q;
  end

  dring_sg_trim #(.AW(AW)) u_trim (
    .raw_len(raw_len), .raw_ptr(raw_ptr),
    .len_o(out_len), .ptr_o(out_ptr), .cnt_o(out_sg_cnt)
  );

  assign out_type   = type_q;
  assign out_cookie = cookie_q;
endmodule

// File: rtl/dring_consumer_chk.sv
module dring_consumer_chk
  import dring_pkg::*;
#(
  parameter int AW        = 64,
  parameter int MAX_SHIFT = 12,
  localparam int SHW      = $clog2(MAX_SHIFT + 1)
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      reply_mode,
  input logic [SHW-1:0]            ring_shift,
  input logic                      rd_req_valid,
  input logic                      rd_req_ready,
  input logic [AW-1:0]             rd_req_addr,
  input logic                      out_valid,
  input logic                      out_ready,
  input logic                      reply_need,
  input logic [63:0]               out_cookie,
  input logic [SG_PAIRS*LEN_W-1:0] out_len,
  input logic [SGC_W-1:0]          out_sg_cnt,
  input logic [MAX_SHIFT-1:0]      cons_idx,
  input logic                      err_fetch_fault,
  input logic                      err_no_buf
);
  assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr));

  assert_req_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |-> rd_req_addr[2:0] == 3'd0);

  assert_out_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !reply_mode && !out_ready |=>
      out_valid && $stable(out_cookie) && $stable(out_len) && $stable(cons_idx));

  assert_idx_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cons_idx >> ring_shift) == '0);

  assert_trim_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_sg_cnt == '0 |-> out_len == '0);

  assert_reply_nonempty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && reply_mode |-> out_sg_cnt != '0);

  assert_fault_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_fetch_fault |=> err_fetch_fault);

  assert_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    reply_mode && reply_need && !out_valid && !err_fetch_fault && !err_no_buf |=> err_no_buf);

  assert_halt_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (err_fetch_fault || err_no_buf) |-> !rd_req_valid && !out_valid);
endmodule

bind desc_ring_consumer dring_consumer_chk #(.AW(AW), .MAX_SHIFT(MAX_SHIFT)) u_chk (
  .clk(clk), .rst_n(rst_n), .reply_mode(reply_mode), .ring_shift(ring_shift),
  .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
  .out_valid(out_valid), .out_ready(out_ready), .reply_need(reply_need),
  .out_cookie(out_cookie), .out_len(out_len), .out_sg_cnt(out_sg_cnt),
  .cons_idx(cons_idx), .err_fetch_fault(err_fetch_fault), .err_no_buf(err_no_buf)
);

// File: tb/test_desc_ring_consumer.sv
`timescale 1ns/1ps
module test_desc_ring_consumer;
  import dring_pkg::*;

  localparam int AW = 64;
  localparam int MS = 12;
  localparam int GAP = 40;
  localparam logic [63:0] BASE = 64'h1000;
  localparam logic [63:0] NO_FAULT = 64'hFFFF_FFFF_FFFF_FFF8;

  // type, cookie, len0, len1, len2
  localparam logic [167:0] VEC [6] = '{
    {8'd11, 64'h0123_4567_89AB_CDEF, 32'h10,   32'h0,    32'h0 },
    {8'd13, 64'hFEDC_BA98_7654_3210, 32'h1000, 32'h1000, 32'h0 },
    {8'd11, 64'h1111_2222_3333_4444, 32'h0,    32'h20,   32'h30},
    {8'd13, 64'h8000_0000_0000_0001, 32'h5,    32'h6,    32'h7 },
    {8'd11, 64'hCAFE_F00D_0000_0042, 32'h40,   32'h0,    32'h50},
    {8'd6,  64'h0,                   32'h0,    32'h0,    32'h0 }
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, reply_mode = 1'b0, db_strobe = 1'b0;
  logic [AW-1:0] ring_base = BASE;
  logic [3:0] ring_shift = 4'd2;
  logic rd_req_valid, rd_req_ready, rd_rsp_valid, rd_rsp_err;
  logic [AW-1:0] rd_req_addr;
  logic [63:0] rd_rsp_data;
  logic out_valid, out_ready = 1'b0, reply_need = 1'b0;
  logic [7:0] out_type;
  logic [63:0] out_cookie;
  logic [3*32-1:0] out_len;
  logic [3*AW-1:0] out_ptr;
  logic [1:0] out_sg_cnt;
  logic [MS-1:0] cons_idx;
  logic err_fetch_fault, err_no_buf;

  logic [63:0] mem [0:31];
  logic [63:0] fault_addr = NO_FAULT;
  int total = 0, bad = 0, req_cnt = 0, vcyc = 0, port_viol = 0;
  bit finished = 1'b0;
  logic prev_wait = 1'b0;
  logic [AW-1:0] prev_addr = '0;
  logic [63:0] off;

  always #4 clk = ~clk;

  desc_ring_consumer #(.AW(AW), .MAX_SHIFT(MS), .POLL_GAP(GAP)) i_desc_ring_consumer (
    .clk(clk), .rst_n(rst_n), .en(en), .reply_mode(reply_mode),
    .ring_base(ring_base), .ring_shift(ring_shift), .db_strobe(db_strobe),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data), .rd_rsp_err(rd_rsp_err),
    .out_valid(out_valid), .out_ready(out_ready), .reply_need(reply_need),
    .out_type(out_type), .out_cookie(out_cookie), .out_len(out_len), .out_ptr(out_ptr),
    .out_sg_cnt(out_sg_cnt), .cons_idx(cons_idx),
    .err_fetch_fault(err_fetch_fault), .err_no_buf(err_no_buf)
  );

  // memory model: alternating ready, one-cycle response
  assign off = rd_req_addr - BASE;
  always @(posedge clk) begin
    if (!rst_n) begin
      rd_req_ready <= 1'b0;
      rd_rsp_valid <= 1'b0;
      rd_rsp_err   <= 1'b0;
      rd_rsp_data  <= '0;
      prev_wait    <= 1'b0;
    end else begin
      rd_req_ready <= ~rd_req_ready;
      rd_rsp_valid <= rd_req_valid && rd_req_ready;
      rd_rsp_data  <= mem[off[7:3]];
      rd_rsp_err   <= (rd_req_addr == fault_addr);
      if (rd_req_valid && rd_req_ready) req_cnt <= req_cnt + 1;
      if (prev_wait && (!rd_req_valid || rd_req_addr != prev_addr)) port_viol <= port_viol + 1;
      if (rd_rsp_valid && rd_req_valid) port_viol <= port_viol + 1;
      prev_wait <= rd_req_valid && !rd_req_ready;
      prev_addr <= rd_req_addr;
    end
    if (out_valid) vcyc <= vcyc + 1;
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ring_bell();
    db_strobe = 1'b1;
    @(negedge clk);
    db_strobe = 1'b0;
  endtask

  task automatic put_desc(input int idx, input logic [7:0] own, input logic [7:0] ty,
                          input logic [63:0] ck, input logic [31:0] a, input logic [31:0] b,
                          input logic [31:0] c, input logic [63:0] pb);
    mem[idx*8+0] = {48'h0, ty, own};
    mem[idx*8+1] = ck;
    mem[idx*8+2] = {32'h5A5A_5A5A, a};
    mem[idx*8+3] = pb;
    mem[idx*8+4] = {32'h5A5A_5A5A, b};
    mem[idx*8+5] = pb + 64'd1;
    mem[idx*8+6] = {32'h5A5A_5A5A, c};
    mem[idx*8+7] = pb + 64'd2;
  endtask

  task automatic wait_valid(input int lim, output bit got);
    got = 1'b0;
    for (int k = 0; k < lim; k++) begin
      @(negedge clk);
      if (out_valid) begin
        got = 1'b1;
        return;
      end
    end
  endtask

  task automatic do_reset(input bit rmode);
    rst_n = 1'b0;
    en = 1'b0;
    reply_mode = rmode;
    out_ready = 1'b0;
    reply_need = 1'b0;
    db_strobe = 1'b0;
    fault_addr = NO_FAULT;
    for (int s = 0; s < 4; s++) put_desc(s, OWN_HOST, 8'd0, 64'd0, 32'd0, 32'd0, 32'd0, 64'd0);
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    en = 1'b1;
  endtask

  function automatic int lead_cnt(input logic [31:0] a, input logic [31:0] b, input logic [31:0] c);
    if (a == 0) return 0;
    if (b == 0) return 1;
    if (c == 0) return 2;
    return 3;
  endfunction

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit got;
    int r0, v0;
    logic [63:0] pb;

    // R1: reset state
    do_reset(1'b0);
    chk(!out_valid, "R1 out_valid after reset", 64'(out_valid), 64'd0);
    chk(cons_idx == 0, "R1 index after reset", 64'(cons_idx), 64'd0);
    chk(!err_fetch_fault && !err_no_buf, "R1 errors after reset",
        64'({err_fetch_fault, err_no_buf}), 64'd0);

    // vector walk: command ring, 4 slots, wraps once
    for (int i = 0; i < 6; i++) begin
      int idx;
      int n;
      logic [31:0] ln [3];
      idx = i % 4;
      pb = 64'hA000_0000 + 64'(i) * 64'h100;
      ln[0] = VEC[i][95:64];
      ln[1] = VEC[i][63:32];
      ln[2] = VEC[i][31:0];
      n = lead_cnt(ln[0], ln[1], ln[2]);
      put_desc(idx, OWN_DEVICE, VEC[i][167:160], VEC[i][159:96], ln[0], ln[1], ln[2], pb);
      ring_bell();
      wait_valid(200, got);
      chk(got, "R6 descriptor presented", 64'(got), 64'd1);
      chk(cons_idx == MS'(idx), "R2 slot index", 64'(cons_idx), 64'(idx));
      chk(out_type == VEC[i][167:160], "R2 type field", 64'(out_type), 64'(VEC[i][167:160]));
      chk(out_cookie == VEC[i][159:96], "R2 cookie field", out_cookie, VEC[i][159:96]);
      chk(out_sg_cnt == 2'(n), "R5 pair count", 64'(out_sg_cnt), 64'(n));
      for (int j = 0; j < 3; j++) begin
        logic [31:0] el;
        logic [63:0] ep;
        el = (j < n) ? ln[j] : 32'd0;
        ep = (j < n) ? pb + 64'(j) : 64'd0;
        chk(out_len[j*32 +: 32] == el, "R5 trimmed length", 64'(out_len[j*32 +: 32]), 64'(el));
        chk(out_ptr[j*AW +: AW] == ep, "R5 trimmed pointer", out_ptr[j*AW +: AW], ep);
      end
      cyc(3);
      chk(out_valid && out_cookie == VEC[i][159:96], "R6 output held", out_cookie, VEC[i][159:96]);
      out_ready = 1'b1;
      @(negedge clk);
      out_ready = 1'b0;
      mem[idx*8] = {48'h0, 8'h0, OWN_HOST};
      if (idx == 3)
        chk(cons_idx == 0, "R7 index wraps", 64'(cons_idx), 64'd0);
      else
        chk(cons_idx == MS'(idx + 1), "R6 index advance", 64'(cons_idx), 64'(idx + 1));
    end

    // R3: foreign ownership byte is ignored
    put_desc(2, 8'hAB, 8'd11, 64'h77, 32'h10, 32'h0, 32'h0, 64'hB000);
    cyc(10);
    r0 = req_cnt;
    v0 = vcyc;
    ring_bell();
    cyc(20);
    chk(req_cnt - r0 == 1, "R3 only owner word read", 64'(req_cnt - r0), 64'd1);
    chk(vcyc == v0, "R3 no output", 64'(vcyc - v0), 64'd0);
    chk(cons_idx == 2, "R3 index unchanged", 64'(cons_idx), 64'd2);

    // R4: slot handed over without doorbell is found by polling
    put_desc(2, OWN_DEVICE, 8'd13, 64'h0BAD_CAFE, 32'h8, 32'h0, 32'h0, 64'hB000);
    wait_valid(150, got);
    chk(got, "R4 poll without doorbell", 64'(got), 64'd1);
    chk(out_cookie == 64'h0BAD_CAFE, "R4 polled cookie", out_cookie, 64'h0BAD_CAFE);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    mem[2*8] = {56'h0, OWN_HOST};

    // R8/R11: read fault on slot 3 word 4
    fault_addr = BASE + 64'd3 * 64 + 64'd4 * 8;
    v0 = vcyc;
    put_desc(3, OWN_DEVICE, 8'd11, 64'h55AA, 32'h10, 32'h20, 32'h0, 64'hC000);
    ring_bell();
    cyc(40);
    chk(err_fetch_fault, "R8 fault flagged", 64'(err_fetch_fault), 64'd1);
    chk(vcyc == v0, "R8 faulted slot not presented", 64'(vcyc - v0), 64'd0);
    r0 = req_cnt;
    cyc(30);
    ring_bell();
    cyc(10);
    chk(req_cnt == r0, "R11 no requests after halt", 64'(req_cnt - r0), 64'd0);
    chk(err_fetch_fault && !out_valid, "R11 halt holds", 64'(out_valid), 64'd0);
    chk(port_viol == 0, "R12 request hold and single outstanding", 64'(port_viol), 64'd0);

    // R10: reply claim with nothing presented
    do_reset(1'b1);
    cyc(5);
    reply_need = 1'b1;
    @(negedge clk);
    reply_need = 1'b0;
    chk(err_no_buf, "R10 drop flagged", 64'(err_no_buf), 64'd1);
    r0 = req_cnt;
    cyc(GAP + 10);
    chk(req_cnt == r0 && err_no_buf, "R11 silent after drop", 64'(req_cnt - r0), 64'd0);

    // R9: reply descriptor without any buffer
    do_reset(1'b1);
    v0 = vcyc;
    put_desc(0, OWN_DEVICE, 8'd0, 64'h99, 32'h0, 32'h0, 32'h0, 64'hD000);
    ring_bell();
    cyc(40);
    chk(err_fetch_fault, "R9 empty reply flagged", 64'(err_fetch_fault), 64'd1);
    chk(vcyc == v0, "R9 empty reply not presented", 64'(vcyc - v0), 64'd0);

    // R10: claim lands in the first presented cycle
    do_reset(1'b1);
    put_desc(0, OWN_DEVICE, 8'd0, 64'h1234, 32'h1000, 32'h1000, 32'h0, 64'hE000);
    ring_bell();
    wait_valid(200, got);
    reply_need = 1'b1;
    @(negedge clk);
    reply_need = 1'b0;
    chk(got, "R10 reply presented", 64'(got), 64'd1);
    chk(!err_no_buf, "R10 same-cycle claim not dropped", 64'(err_no_buf), 64'd0);
    chk(cons_idx == 1, "R10 same-cycle claim takes slot", 64'(cons_idx), 64'd1);
    chk(port_viol == 0, "R12 port rules in reply runs", 64'(port_viol), 64'd0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule